// File: doc/BRIEF.md
# Square-Wave Tone Voice

This block is one tone voice of a programmable sound generator. A fast master clock is first divided by a fixed prescale factor (16 by default) to make a slow counting tick. A 10-bit down-counter runs on that tick. Each time it borrows, it reloads from the period input and inverts a one-bit square wave. The voice therefore divides the tick by N and then by two. A period of 1 gives the fastest square wave, and a period of 0 gives the slowest, acting as 1024.

The square bit is scaled by a 4-bit attenuation into a unipolar 4-bit level. The level swings between zero and a positive amplitude and never goes below zero. This is what lets software play samples by varying the attenuation of a voice that runs at its fastest rate.

A new attenuation waits for the start of the next tone cycle before it takes effect. A new period waits for the next reload, and writing it does not restart the counter. Register decoding, mixing of several voices and analog filtering belong to other blocks.

Top module: `sq_tone_voice`

## Requirements
- R1: The internal tick fires once per DIV cycles in which `clk_en` is high (DIV defaults to 16). While `clk_en` is low, no state advances and `sq_out` holds.
- R2: For a period N from 1 to 1023, `sq_out` stays constant for exactly N ticks (N·DIV enabled clocks) between successive inversions.
- R3: A period of 1 inverts `sq_out` on every tick, so it is the highest-rate square wave and never a held level.
- R4: A period of 0 acts as 1024: `sq_out` holds for 1024 ticks between inversions.
- R5: `level` equals 15 minus the attenuation currently in use while `sq_out` is 1, and 0 while `sq_out` is 0. Attenuation 15 is silent and attenuation 0 gives level 15.
- R6: A change on `atten` is taken up only when `sq_out` rises from 0 to 1, which is the start of a tone cycle. Until then `level` keeps the previous amplitude.
- R7: A change on `period` does not restart the count in progress. The half-cycle already under way keeps its old length, and the new value sets the length of the half-cycles that follow.
- R8: Reset drives `sq_out` to 0 and `level` to 0, clears the counter and makes the attenuation in use 15. After reset is released, the first inversion comes 1024 ticks (16384 clocks at DIV 16) later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Master-clock qualifier; prescaler counts only while high |
| period | input | 10 | Half-period in ticks; 0 means 1024 |
| atten | input | 4 | Attenuation; 15 silent, 0 loudest |
| sq_out | output | 1 | Raw square-wave bit |
| level | output | 4 | Unipolar output amplitude |

## Verification
The bench measures the time between inversions of the square bit over a sweep of periods. The sweep covers 1, several small values, large values and 0. Together these separate a correct divide-by-N from an off-by-one reload, from a held output at period 1, and from a special case at period 0.

A period written in the middle of a half-cycle shows whether the counter restarts or waits for the next reload. A clock qualifier held low, and one that toggles every cycle, show whether the prescaler counts only enabled cycles.

All sixteen attenuations are stepped through while both phases of the square are sampled, which checks the unipolar scaling. An attenuation written in the middle of a high phase shows whether the update is held back until the next rising edge.

// File: rtl/sq_pkg.sv
package sq_pkg;
    localparam int PER_W = 10;
    localparam int ATT_W = 4;

    typedef logic [PER_W-1:0] period_t;
    typedef logic [ATT_W-1:0] att_t;

    typedef struct packed {
        period_t cnt;
        logic    sq;
    } div_st_t;

    typedef struct packed {
        att_t att;
    } lvl_st_t;
endpackage

// File: rtl/sq_prescale.sv
module sq_prescale #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (clk_en) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
                tick     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sq_divider.sv
module sq_divider
    import sq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    input  period_t period,
    output logic    sq,
    output logic    cycle_start
);
    localparam period_t ONE = period_t'(1);

    div_st_t st_d, st_q;

    // Borrow happens when a tick meets a count of one; a reloaded 0 wraps
    // through the full range first, so it behaves as 1024.
    always_comb begin
        st_d        = st_q;
        cycle_start = 1'b0;
        if (tick) begin
            if (st_q.cnt == ONE) begin
                st_d.cnt    = period;
                st_d.sq     = ~st_q.sq;
                cycle_start = ~st_q.sq;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sq = st_q.sq;
endmodule

// File: rtl/sq_level.sv
module sq_level
    import sq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cycle_start,
    input  logic sq,
    input  att_t atten,
    output att_t level
);
    localparam att_t ATT_MAX = '1;

    lvl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cycle_start) st_d.att = atten;
        level = sq ? (ATT_MAX - st_q.att) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{att: ATT_MAX};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sq_tone_voice.sv
module sq_tone_voice
    import sq_pkg::*;
#(
    parameter int DIV = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic [PER_W-1:0] period,
    input  logic [ATT_W-1:0] atten,
    output logic             sq_out,
    output logic [ATT_W-1:0] level
);
    logic tick;
    logic cycle_start;

    sq_prescale #(.DIV(DIV)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_en (clk_en),
        .tick   (tick)
    );

    sq_divider u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .period      (period),
        .sq          (sq_out),
        .cycle_start (cycle_start)
    );

    sq_level u_lvl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cycle_start (cycle_start),
        .sq          (sq_out),
        .atten       (atten),
        .level       (level)
    );
endmodule

// File: rtl/sq_tone_voice_chk.sv
module sq_tone_voice_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clk_en,
    input logic       tick,
    input logic       sq,
    input logic [3:0] level
);
    AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> clk_en); // R1
    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R1
    AST_SQ_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sq)); // R2
    AST_LEVEL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !sq |-> (level == 4'd0)); // R5
    AST_LEVEL_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sq && $past(sq)) |-> $stable(level)); // R6
endmodule

bind sq_tone_voice sq_tone_voice_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clk_en (clk_en),
    .tick   (tick),
    .sq     (sq_out),
    .level  (level)
);

// File: tb/sq_tone_voice_bench.sv
module sq_tone_voice_bench;
    localparam int CLK_P = 10;
    localparam int DIV   = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b1;
    logic [9:0] period = 10'd5;
    logic [3:0] atten = 4'd15;
    logic       sq_out;
    logic [3:0] level;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    sq_tone_voice #(.DIV(DIV)) u_sq_tone_voice (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_en (clk_en),
        .period (period),
        .atten  (atten),
        .sq_out (sq_out),
        .level  (level)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_edge(output int t);
        logic p;
        p = sq_out;
        do @(negedge clk); while (sq_out == p);
        t = cyc;
    endtask

    task automatic wait_rise();
        int t;
        do wait_edge(t); while (sq_out != 1'b1);
    endtask

    task automatic wait_fall();
        int t;
        do wait_edge(t); while (sq_out != 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int t0, t1, t2;
        repeat (4) @(negedge clk);
        // R8: reset state
        chk(sq_out == 1'b0, "R8 sq after reset", sq_out, 0);
        chk(level == 4'd0, "R8 level after reset", level, 0);
        rst_n = 1'b1;
        t0 = cyc;
        wait_edge(t1);
        chk((t1 - t0) == 1024*DIV, "R8 first inversion delay", t1 - t0, 1024*DIV);

        // R2/R3: period sweep
        foreach (period_list[i]) begin
            period = period_list[i];
            wait_edge(t0);
            wait_edge(t1);
            wait_edge(t2);
            chk((t2 - t1) == period_list[i]*DIV,
                (period_list[i] == 1) ? "R3 period 1 half-cycle" : "R2 half-cycle",
                t2 - t1, period_list[i]*DIV);
        end

        // R4: period 0 acts as 1024
        period = 10'd0;
        wait_edge(t0);
        wait_edge(t1);
        wait_edge(t2);
        chk((t2 - t1) == 1024*DIV, "R4 period 0", t2 - t1, 1024*DIV);

        // R7: period change mid half-cycle
        period = 10'd50;
        wait_edge(t0);
        wait_edge(t0);
        period = 10'd3;
        wait_edge(t1);
        chk((t1 - t0) == 50*DIV, "R7 old period kept", t1 - t0, 50*DIV);
        wait_edge(t2);
        chk((t2 - t1) == 3*DIV, "R7 new period used", t2 - t1, 3*DIV);

        // R1: clk_en low freezes the voice
        period = 10'd1;
        wait_edge(t0);
        clk_en = 1'b0;
        begin
            logic s0;
            int   flips;
            s0 = sq_out;
            flips = 0;
            for (int k = 0; k < 100; k++) begin
                @(negedge clk);
                if (sq_out != s0) flips++;
            end
            chk(flips == 0, "R1 frozen while disabled", flips, 0);
        end
        // R1: clk_en every other cycle doubles the spacing
        period = 10'd2;
        fork
            begin
                for (int k = 0; k < 2000; k++) begin
                    @(negedge clk);
                    clk_en = ~clk_en;
                end
            end
            begin
                wait_edge(t0);
                wait_edge(t0);
                wait_edge(t1);
                chk((t1 - t0) == 2*2*DIV, "R1 half-rate enable", t1 - t0, 4*DIV);
            end
        join
        clk_en = 1'b1;

        // R5: attenuation sweep
        period = 10'd2;
        for (int a = 0; a < 16; a++) begin
            atten = 4'(a);
            wait_rise();
            chk(level == 4'(15 - a), "R5 level while high", level, 15 - a);
            wait_fall();
            chk(level == 4'd0, "R5 level while low", level, 0);
        end

        // R6: attenuation change held to next rising edge
        period = 10'd8;
        atten = 4'd3;
        wait_rise();
        wait_rise();
        chk(level == 4'd12, "R6 level before change", level, 12);
        atten = 4'd10;
        repeat (5) @(negedge clk);
        chk(level == 4'd12, "R6 level held mid-cycle", level, 12);
        wait_fall();
        chk(level == 4'd0, "R6 level low phase", level, 0);
        wait_rise();
        chk(level == 4'd5, "R6 level after boundary", level, 5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    int period_list [8] = '{1, 2, 3, 4, 7, 13, 64, 255};
endmodule